// File: doc/BRIEF.md
# Serial-Bus Controlled Open-Drain Port Bank

This block is an I2C target with exactly one byte of state: a control register whose bits decide which of eight open-drain outputs sink current. A set bit turns its port on, so the port pulls its pin low. A clear bit leaves the pin at high impedance. SCL and SDA are oversampled by the system clock. SDA comes in as a level and goes out as a pull-low enable, which the board combines with the controller's drive as a wired-AND.

The controller writes the register with a single-byte write and reads it back with a read of any length. A written byte is parked and reaches the ports only when the bus signals STOP. This lets a controller line up a new pattern while the old one is still showing. A repeated START does not apply the parked byte. Two clears exist. The system reset `rst` is synchronous and active high, and it stands for the power-on hold. The separate active-low `clear_n` input zeroes the register, drops any parked byte and returns the bus engine to idle.

Top module: `iop_sink_port`

## Requirements
- R1: The 7-bit target address, sent MSB first, is binary 1100 followed by `addr_sel_i[2]`, `addr_sel_i[1]`, `addr_sel_i[0]`. The eighth bit is R/W, where 0 means write and 1 means read. On a match the block holds SDA low during the ninth clock (ACK).
- R2: When the address does not match, the block never pulls SDA until the next START or STOP, and the bytes that follow leave the ports unchanged.
- R3: The first data byte of a write is acknowledged. Once applied, bit n of that byte drives `port_sink_o[n]`, and a 1 means the port sinks. For example, 0xC1 turns on ports 0, 6 and 7 only.
- R4: `port_sink_o` changes only as a result of a STOP condition (SDA rising while SCL is high) or a clear. A written byte is not visible on the ports before its STOP.
- R5: A repeated START keeps the parked byte without applying it. A later write replaces the parked byte, and only the last one reaches the ports at the final STOP. START and STOP both release SDA.
- R6: Within one write, every data byte after the first is not acknowledged and is discarded.
- R7: A read returns the applied register value MSB first, one bit per SCL clock.
- R8: If the controller ACKs a read byte, the block sends the same register byte again. A NACK ends the transfer.
- R9: While `clear_n` is low, the register and the parked byte are cleared and SDA is released. A STOP that falls inside the clear applies nothing.
- R10: While `rst` is high, the ports are all off (0) and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset (power-on hold) |
| clear_n | input | 1 | Active-low clear of register, parked byte and bus engine |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 3 | Low three address bits |
| port_sink_o | output | 8 | Per-port sink enable, 1 = pulling low |

## Verification
Two events can land on the same clock: the STOP that would apply a parked byte, and the active-low clear that wipes it. The bench parks a byte, drops `clear_n` and then performs the STOP with the clear still held. It expects the ports to read zero afterwards and to stay at zero. The other events are compared against a behavioural model on every clock. The model accepts the old or the new port value only during a short settling window after each STOP.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 3;
    localparam int PREFIX_W = BYTE_W - 1 - SEL_W;
    localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b1100;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] rx,
                                      input logic [SEL_W-1:0]  sel);
        return rx[BYTE_W-1:1] == {ADDR_PREFIX, sel};
    endfunction

endpackage

// File: rtl/iop_line_filter.sv
module iop_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          sync1, sync2;
    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (clr) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            clean <= 1'b1;
            run   <= '0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            if (sync2 == clean) begin
                run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
                clean <= sync2;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/iop_bus_events.sv
module iop_bus_events
    import iop_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     scl_c,
    input  logic     sda_c,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_c;
            sda_q <= sda_c;
        end
    end

    always_comb begin
        evt.start    = scl_q & scl_c & sda_q & ~sda_c;
        evt.stop     = scl_q & scl_c & ~sda_q & sda_c;
        evt.scl_rise = ~scl_q & scl_c;
        evt.scl_fall = scl_q & ~scl_c;
        evt.sda      = sda_c;
    end
endmodule

// File: rtl/iop_target_fsm.sv
module iop_target_fsm
    import iop_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  bus_evt_t          evt,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] cur_reg,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    tgt_state_e           state;
    logic [BYTE_W-1:0]    shreg;
    logic [BYTE_W-1:0]    txreg;
    logic [BIT_CNT_W-1:0] nbits;
    logic                 rd_mode;
    logic                 ctl_ack;

    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST = BIT_CNT_W'(BYTE_W - 1);

    assign wr_byte = shreg;

    always_ff @(posedge clk) begin
        if (clr) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            txreg    <= '0;
            nbits    <= '0;
            rd_mode  <= 1'b0;
            ctl_ack  <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state    <= ST_ADDR;
                nbits    <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: begin
                        sda_pull <= 1'b0;
                    end
                    ST_ADDR, ST_WDATA: begin
                        if (evt.scl_rise && nbits != FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            nbits <= nbits + 1'b1;
                        end else if (evt.scl_fall && nbits == FULL) begin
                            nbits <= '0;
                            if (state == ST_WDATA) begin
                                wr_stb   <= 1'b1;
                                sda_pull <= 1'b1;
                                state    <= ST_WACK;
                            end else if (addr_hit(shreg, sel)) begin
                                rd_mode  <= shreg[0];
                                sda_pull <= 1'b1;
                                state    <= ST_AACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.scl_fall) begin
                            nbits <= '0;
                            if (rd_mode) begin
                                txreg    <= cur_reg;
                                sda_pull <= ~cur_reg[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_SKIP;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (nbits == LAST) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                sda_pull <= ~txreg[BYTE_W-2];
                                txreg    <= {txreg[BYTE_W-2:0], 1'b0};
                                nbits    <= nbits + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            ctl_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            nbits <= '0;
                            if (ctl_ack) begin
                                txreg    <= cur_reg;
                                sda_pull <= ~cur_reg[BYTE_W-1];
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/iop_port_reg.sv
module iop_port_reg
    import iop_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              stop,
    output logic [BYTE_W-1:0] applied
);
    logic [BYTE_W-1:0] parked;
    logic              parked_vld;

    always_ff @(posedge clk) begin
        if (clr) begin
            parked     <= '0;
            parked_vld <= 1'b0;
            applied    <= '0;
        end else begin
            if (stop && parked_vld) begin
                applied    <= parked;
                parked_vld <= 1'b0;
            end
            if (wr_stb) begin
                parked     <= wr_byte;
                parked_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iop_sink_port.sv
module iop_sink_port
    import iop_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [SEL_W-1:0]  addr_sel_i,
    output logic [BYTE_W-1:0] port_sink_o
);
    localparam int NLINES = 2;

    logic              clr;
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    bus_evt_t          bus_evt;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic              start_seen;
    logic              stop_seen;

    assign clr       = rst | ~clear_n;
    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        iop_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .clr   (clr),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    iop_bus_events u_evt (
        .clk   (clk),
        .clr   (clr),
        .scl_c (clean_lines[0]),
        .sda_c (clean_lines[1]),
        .evt   (bus_evt)
    );

    assign start_seen = bus_evt.start;
    assign stop_seen  = bus_evt.stop;

    iop_target_fsm u_fsm (
        .clk      (clk),
        .clr      (clr),
        .evt      (bus_evt),
        .sel      (addr_sel_i),
        .cur_reg  (port_sink_o),
        .sda_pull (sda_pull_o),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte)
    );

    iop_port_reg u_reg (
        .clk     (clk),
        .clr     (clr),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .stop    (stop_seen),
        .applied (port_sink_o)
    );
endmodule

// File: rtl/iop_sink_port_chk.sv
module iop_sink_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       clear_n,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       sda_pull_o,
    input logic [7:0] port_sink_o
);
    // R4: ports move only after a STOP or a clear
    a_r4_change_needs_stop: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_sink_o) |-> ($past(stop_seen) || !$past(clear_n)));

    // R4: STOP leaves SDA released
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_pull_o);

    // R5: START leaves SDA released
    a_r5_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> !sda_pull_o);

    // R9: clear zeroes ports and frees SDA
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (port_sink_o == 8'h00 && !sda_pull_o));

    // R10: reset holds ports off and SDA free
    a_r10_reset_state: assert property (@(posedge clk) disable iff (!clear_n)
        rst |=> (port_sink_o == 8'h00 && !sda_pull_o));
endmodule

bind iop_sink_port iop_sink_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_n     (clear_n),
    .start_seen  (start_seen),
    .stop_seen   (stop_seen),
    .sda_pull_o  (sda_pull_o),
    .port_sink_o (port_sink_o)
);

// File: tb/iop_sink_port_test.sv
`timescale 1ns/1ps
module iop_sink_port_test;
    localparam int Q = 10;
    localparam int SETTLE = 16;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [6:0] MY_ADDR = {4'b1100, SEL};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_n = 1'b1;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_i, sda_i, sda_pull_o;
    logic [7:0] port_sink_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit mon_on = 0;

    // behavioural model state
    logic [7:0] exp_ports = 8'h00;
    logic [7:0] old_ports = 8'h00;
    logic [7:0] pend = 8'h00;
    bit         pend_vld = 0;
    int         settle = 0;

    always #5 clk = ~clk;

    assign scl_i = ~m_scl_low;
    assign sda_i = ~(m_sda_low | sda_pull_o);

    iop_sink_port uut (
        .clk(clk), .rst(rst), .clear_n(clear_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_pull_o(sda_pull_o), .addr_sel_i(SEL), .port_sink_o(port_sink_o)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R4)
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (settle > 0) begin
                check(port_sink_o == exp_ports || port_sink_o == old_ports, "R4 ports during settle", port_sink_o, exp_ports);
                settle--;
            end else begin
                check(port_sink_o == exp_ports, "R4 ports vs model", port_sink_o, exp_ports);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wt(Q);
        m_scl_low = 1'b0; wt(2*Q);
        m_sda_low = 1'b1; wt(2*Q);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wt(Q);
        m_scl_low = 1'b0; wt(2*Q);
        m_sda_low = 1'b0;
        if (pend_vld && clear_n) begin
            old_ports = exp_ports;
            exp_ports = pend;
            pend_vld  = 0;
            settle    = SETTLE;
        end
        wt(2*Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = ~b; wt(Q);
        m_scl_low = 1'b0; wt(2*Q);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; wt(Q);
        m_scl_low = 1'b0; wt(Q);
        b = sda_i; wt(Q);
        m_scl_low = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic write_first(input logic [7:0] d);
        bit ak;
        send_byte({MY_ADDR, 1'b0}, ak);
        check(ak, "R1 write address ACK", {7'd0, ak}, 8'h01);
        send_byte(d, ak);
        check(ak, "R3 first data byte ACK", {7'd0, ak}, 8'h01);
        pend = d;
        pend_vld = 1;
    endtask

    initial begin
        bit ak;
        logic [7:0] rd;
        wt(6);
        check(port_sink_o == 8'h00 && !sda_pull_o, "R10 reset state", port_sink_o, 8'h00);
        rst = 1'b0;
        wt(4);
        mon_on = 1;

        // R3/R4: write 0xC1, not visible before STOP
        bus_start();
        write_first(8'hC1);
        wt(40);
        check(port_sink_o == 8'h00, "R4 no change before STOP", port_sink_o, 8'h00);
        bus_stop();
        wt(30);
        check(port_sink_o == 8'hC1, "R3 ports 0,6,7 sink", port_sink_o, 8'hC1);

        // R7: read back
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ak);
        check(ak, "R1 read address ACK", {7'd0, ak}, 8'h01);
        recv_byte(0, rd);
        check(rd == 8'hC1, "R7 read value", rd, 8'hC1);
        bus_stop();

        // R8: controller ACK repeats the byte
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ak);
        recv_byte(1, rd);
        check(rd == 8'hC1, "R8 first read byte", rd, 8'hC1);
        recv_byte(0, rd);
        check(rd == 8'hC1, "R8 repeated read byte", rd, 8'hC1);
        bus_stop();

        // R2: other select bits, and other prefix
        bus_start();
        send_byte({4'b1100, 3'b100, 1'b0}, ak);
        check(!ak, "R2 wrong select NACK", {7'd0, ak}, 8'h00);
        send_byte(8'h3C, ak);
        check(!ak, "R2 data after mismatch NACK", {7'd0, ak}, 8'h00);
        bus_stop();
        bus_start();
        send_byte({4'b0100, SEL, 1'b0}, ak);
        check(!ak, "R2 wrong prefix NACK", {7'd0, ak}, 8'h00);
        bus_stop();
        wt(30);
        check(port_sink_o == 8'hC1, "R2 ports unchanged", port_sink_o, 8'hC1);

        // R5: repeated START keeps and then overwrites the parked byte
        bus_start();
        write_first(8'h0F);
        bus_start();
        wt(30);
        check(port_sink_o == 8'hC1, "R5 repeated START applies nothing", port_sink_o, 8'hC1);
        write_first(8'h5A);
        bus_stop();
        wt(30);
        check(port_sink_o == 8'h5A, "R5 last write applied", port_sink_o, 8'h5A);

        // R6: second data byte discarded
        bus_start();
        write_first(8'h33);
        send_byte(8'h99, ak);
        check(!ak, "R6 second byte NACK", {7'd0, ak}, 8'h00);
        bus_stop();
        wt(30);
        check(port_sink_o == 8'h33, "R6 first byte kept", port_sink_o, 8'h33);

        // R9: clear held across the STOP that would apply 0xFF
        bus_start();
        write_first(8'hFF);
        clear_n = 1'b0;
        old_ports = exp_ports; exp_ports = 8'h00; pend_vld = 0; settle = 3;
        wt(2);
        check(port_sink_o == 8'h00 && !sda_pull_o, "R9 clear zeroes", port_sink_o, 8'h00);
        bus_stop();
        clear_n = 1'b1;
        wt(30);
        check(port_sink_o == 8'h00, "R9 STOP under clear applies nothing", port_sink_o, 8'h00);

        // R9: bus usable after clear
        bus_start();
        write_first(8'h81);
        bus_stop();
        wt(30);
        check(port_sink_o == 8'h81, "R9 write after clear", port_sink_o, 8'h81);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule